// File: doc/BRIEF.md
# SDRAM Burst Access Sequencer

This block converts one host burst request of four 32-bit beats into a timed series of SDRAM commands on a single chip select. The memory's internal burst length is assumed to be one. The sequencer opens the row with an activate command and steps the column address itself. It issues its own READ or WRITE for each beat, and after the last beat it closes every bank with a precharge-all. Read data is picked up from the data bus a CAS latency after each READ. Write data and its byte enables go out in the same cycle as the matching WRITE.

Three static configuration inputs set the timing, each in clock counts: the activate-to-column delay, the CAS latency (1 to 3) and the precharge-to-activate delay. A request is taken when `reqValid` and `reqReady` are both high at a rising edge. The host can hand over its next request while the current burst is still precharging. The sequencer holds that request until the precharge delay has run out and then activates. One `done` pulse marks the end of each burst.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset, and while no burst is in progress, the command pins show NOP, `reqReady` is 1, and `rdValid`, `done` and `sdDqOe` are 0.
- R2: When a request is accepted while idle, an ACTV command ({CS,RAS,CAS,WE} = 0011) appears in the next cycle with the request row on `sdAddr`, zero-extended. Each burst issues exactly one ACTV.
- R3: The first column command appears `cfgTrcd` cycles after ACTV. It is followed directly by the other three, one per cycle. Beat i carries column (reqCol + i) mod 2^COL_W on `sdAddr`. READ is 0101 and WRITE is 0100.
- R4: During the WRITE of beat i, `sdDqOe` is 1 and `sdDqOut` equals bits [32i+31:32i] of `reqWrData`. In the same cycle `sdBe` (active-high byte enables) equals bits [4i+3:4i] of `reqWrBe`. `sdDqOe` is 0 in every other cycle.
- R5: During every READ, `sdBe` is 4'b1111. The value on `sdDqIn` in the cycle that lies `cfgCasLat` cycles after the READ of beat i is shown on `rdData`, with `rdValid` high, in the cycle that follows. The beats arrive in order.
- R6: A PALL command (0010) with `sdAddr` bit 10 high appears in the cycle directly after the fourth column command.
- R7: An ACTV never appears earlier than `cfgTrp` cycles after the preceding PALL. `reqReady` is high during PALL and the precharge wait while no request is held. A request accepted then has its ACTV exactly `cfgTrp` cycles after the PALL.
- R8: `done` is a single-cycle pulse. On a read burst it coincides with the fourth `rdValid`. On a write burst it coincides with the fourth WRITE.
- R9: Every cycle that carries no ACTV, column command or PALL shows NOP (0111) on the command pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| cfgTrcd | input | 3 | Activate-to-column delay in clocks (1..7) |
| cfgCasLat | input | 2 | CAS latency in clocks (1..3) |
| cfgTrp | input | 3 | Precharge-to-activate delay in clocks (1..7) |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Sequencer can take a request |
| reqWrite | input | 1 | 1 = write burst, 0 = read burst |
| reqRow | input | 13 | Row address |
| reqCol | input | 9 | Starting column address |
| reqWrData | input | 128 | Write data, beat i in bits [32i+31:32i] |
| reqWrBe | input | 16 | Write byte enables, beat i in bits [4i+3:4i] |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdAddr | output | 13 | Multiplexed row/column address |
| sdBe | output | 4 | Byte enables, active high |
| sdDqOut | output | 32 | Data driven to the memory |
| sdDqOe | output | 1 | Output enable for sdDqOut |
| sdDqIn | input | 32 | Data returned by the memory |
| rdValid | output | 1 | Read beat valid on rdData |
| rdData | output | 32 | Captured read beat |
| done | output | 1 | Burst completion pulse |

## Verification
Several properties are checked on every cycle: the gap from ACTV to the first column command, the unbroken run of column commands with a rising column, PALL directly after the last beat, the precharge guard before any ACTV, and bit 10 during PALL. Also checked each cycle are full byte enables on reads, data drive only alongside WRITE, and `done` lasting a single cycle. Other behaviour is only visible through the bench's scenarios, which compare a complete per-cycle reference timeline. These cover exact read capture timing for every CAS latency, the beat order of returned data, and column wrap-around at the top of the column range. They also cover a request taken during PALL or the precharge wait whose ACTV lands exactly on the guard boundary.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_RCD,
    ST_COL,
    ST_PALL,
    ST_TRP
  } seqState_t;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic       load;
    logic       act;
    logic       col;
    logic       pall;
    logic       wr;
    logic [3:0] beat;
  } seqStrobe_t;

  localparam logic [3:0] CMD_NOP   = 4'b0111;
  localparam logic [3:0] CMD_ACTV  = 4'b0011;
  localparam logic [3:0] CMD_READ  = 4'b0101;
  localparam logic [3:0] CMD_WRITE = 4'b0100;
  localparam logic [3:0] CMD_PALL  = 4'b0010;

endpackage

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int BEATS = 4,
  parameter int CNT_W = 3,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cfgTrcd,
  input  logic [CNT_W-1:0] cfgTrp,
  input  logic             reqValid,
  input  logic             reqWrite,
  output logic             reqReady,
  output seqStrobe_t       strobe
);

  seqState_t         state, stateNext;
  logic [CNT_W-1:0]  cnt, cntNext;
  logic [BEAT_W-1:0] beat, beatNext;
  logic              isWr;
  logic              pending;
  logic              accept;
  logic              haveReq;
  logic              lastBeat;

  assign reqReady = (state == ST_IDLE) ||
                    (((state == ST_PALL) || (state == ST_TRP)) && !pending);
  assign accept   = reqValid && reqReady;
  assign haveReq  = pending || accept;
  assign lastBeat = (beat == BEAT_W'(BEATS - 1));

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    beatNext  = beat;
    case (state)
      ST_IDLE: if (accept) stateNext = ST_ACT;
      ST_ACT: begin
        beatNext = '0;
        if (cfgTrcd <= CNT_W'(1)) begin
          stateNext = ST_COL;
        end else begin
          stateNext = ST_RCD;
          cntNext   = cfgTrcd - CNT_W'(1);
        end
      end
      ST_RCD: begin
        if (cnt <= CNT_W'(1)) stateNext = ST_COL;
        else cntNext = cnt - CNT_W'(1);
      end
      ST_COL: begin
        beatNext = beat + BEAT_W'(1);
        if (lastBeat) stateNext = ST_PALL;
      end
      ST_PALL: begin
        if (cfgTrp <= CNT_W'(1)) begin
          stateNext = haveReq ? ST_ACT : ST_IDLE;
        end else begin
          stateNext = ST_TRP;
          cntNext   = cfgTrp - CNT_W'(1);
        end
      end
      ST_TRP: begin
        if (cnt <= CNT_W'(1)) stateNext = haveReq ? ST_ACT : ST_IDLE;
        else cntNext = cnt - CNT_W'(1);
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      beat    <= '0;
      isWr    <= 1'b0;
      pending <= 1'b0;
    end else begin
      state   <= stateNext;
      cnt     <= cntNext;
      beat    <= beatNext;
      pending <= haveReq && (stateNext != ST_ACT);
      if (accept) isWr <= reqWrite;
    end
  end

  always_comb begin
    strobe      = '0;
    strobe.load = accept;
    strobe.act  = (state == ST_ACT);
    strobe.col  = (state == ST_COL);
    strobe.pall = (state == ST_PALL);
    strobe.wr   = isWr;
    strobe.beat = 4'(beat);
  end

  // ---------------- assertions ----------------
  logic [7:0] sinceAct;
  logic [7:0] sincePall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceAct  <= 8'd0;
      sincePall <= 8'hFF;
    end else begin
      if (strobe.act) sinceAct <= 8'd1;
      else if (sinceAct != 8'hFF) sinceAct <= sinceAct + 8'd1;
      if (strobe.pall) sincePall <= 8'd1;
      else if (sincePall != 8'hFF) sincePall <= sincePall + 8'd1;
    end
  end

  initial begin
    assert (BEATS >= 1 && BEATS <= 16);
  end

  AST_RCD_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.col && beat == '0) |-> (sinceAct == 8'(cfgTrcd))); // R3

  AST_BEATS_CONTIG: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.col && !lastBeat) |=> (strobe.col && beat == $past(beat) + BEAT_W'(1))); // R3

  AST_PALL_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.col && lastBeat) |=> strobe.pall); // R6

  AST_TRP_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.act |-> (sincePall >= 8'(cfgTrp))); // R7

endmodule

// File: rtl/sdram_seq_dp.sv
module sdram_seq_dp
  import sdram_seq_pkg::*;
#(
  parameter int BEATS  = 4,
  parameter int DATA_W = 32,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 13,
  parameter int MAX_CL = 3,
  parameter int CL_W   = 2,
  localparam int BE_W   = DATA_W / 8,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seqStrobe_t              strobe,
  input  logic [CL_W-1:0]         cfgCasLat,
  input  logic [ROW_W-1:0]        reqRow,
  input  logic [COL_W-1:0]        reqCol,
  input  logic [BEATS*DATA_W-1:0] reqWrData,
  input  logic [BEATS*BE_W-1:0]   reqWrBe,
  output logic                    sdCsN,
  output logic                    sdRasN,
  output logic                    sdCasN,
  output logic                    sdWeN,
  output logic [ADDR_W-1:0]       sdAddr,
  output logic [BE_W-1:0]         sdBe,
  output logic [DATA_W-1:0]       sdDqOut,
  output logic                    sdDqOe,
  input  logic [DATA_W-1:0]       sdDqIn,
  output logic                    rdValid,
  output logic [DATA_W-1:0]       rdData,
  output logic                    done
);

  logic [ROW_W-1:0]             rowQ;
  logic [COL_W-1:0]             colQ;
  logic [BEATS-1:0][DATA_W-1:0] dataQ;
  logic [BEATS-1:0][BE_W-1:0]   beQ;
  logic [BEAT_W-1:0]            beatIdx;
  logic [COL_W-1:0]             colNow;
  logic                         lastBeat;
  logic [3:0]                   cmd;
  logic [MAX_CL-1:0]            pipeV;
  logic [MAX_CL-1:0]            pipeL;
  logic                         rdLastQ;
  logic                         capV;
  logic                         capL;

  assign beatIdx  = strobe.beat[BEAT_W-1:0];
  assign colNow   = colQ + COL_W'(beatIdx);
  assign lastBeat = (beatIdx == BEAT_W'(BEATS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ <= '0;
      colQ <= '0;
    end else if (strobe.load) begin
      rowQ <= reqRow;
      colQ <= reqCol;
    end
  end

  for (genvar g = 0; g < BEATS; g++) begin : gBeat
    always_ff @(posedge clk) begin
      if (!rstN) begin
        dataQ[g] <= '0;
        beQ[g]   <= '0;
      end else if (strobe.load) begin
        dataQ[g] <= reqWrData[g*DATA_W +: DATA_W];
        beQ[g]   <= reqWrBe[g*BE_W +: BE_W];
      end
    end
  end

  always_comb begin
    cmd     = CMD_NOP;
    sdAddr  = '0;
    sdBe    = '1;
    sdDqOut = '0;
    sdDqOe  = 1'b0;
    if (strobe.act) begin
      cmd                = CMD_ACTV;
      sdAddr[ROW_W-1:0]  = rowQ;
    end else if (strobe.col) begin
      sdAddr[COL_W-1:0]  = colNow;
      if (strobe.wr) begin
        cmd     = CMD_WRITE;
        sdBe    = beQ[beatIdx];
        sdDqOut = dataQ[beatIdx];
        sdDqOe  = 1'b1;
      end else begin
        cmd     = CMD_READ;
      end
    end else if (strobe.pall) begin
      cmd        = CMD_PALL;
      sdAddr[10] = 1'b1;
    end
  end

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = cmd;

  // read return pipeline, one stage per clock of latency
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipeV <= '0;
      pipeL <= '0;
    end else begin
      pipeV[0] <= strobe.col && !strobe.wr;
      pipeL[0] <= strobe.col && !strobe.wr && lastBeat;
      for (int k = 1; k < MAX_CL; k++) begin
        pipeV[k] <= pipeV[k-1];
        pipeL[k] <= pipeL[k-1];
      end
    end
  end

  assign capV = pipeV[cfgCasLat - CL_W'(1)];
  assign capL = pipeL[cfgCasLat - CL_W'(1)];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdLastQ <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= capV;
      rdLastQ <= capL;
      if (capV) rdData <= sdDqIn;
    end
  end

  assign done = rdLastQ || (strobe.col && strobe.wr && lastBeat);

  // ---------------- assertions ----------------
  initial begin
    assert (ADDR_W > 10 && ROW_W <= ADDR_W && COL_W <= ADDR_W);
  end

  AST_PALL_A10: assert property (@(posedge clk) disable iff (!rstN)
    ({sdCsN, sdRasN, sdCasN, sdWeN} == CMD_PALL) |-> sdAddr[10]); // R6

  AST_READ_BE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    ({sdCsN, sdRasN, sdCasN, sdWeN} == CMD_READ) |-> (&sdBe)); // R5

  AST_OE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    sdDqOe |-> ({sdCsN, sdRasN, sdCasN, sdWeN} == CMD_WRITE)); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_seq_pkg::*;
#(
  parameter int BEATS  = 4,
  parameter int DATA_W = 32,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 13,
  parameter int CNT_W  = 3,
  parameter int MAX_CL = 3,
  parameter int CL_W   = 2,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [CNT_W-1:0]        cfgTrcd,
  input  logic [CL_W-1:0]         cfgCasLat,
  input  logic [CNT_W-1:0]        cfgTrp,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic                    reqWrite,
  input  logic [ROW_W-1:0]        reqRow,
  input  logic [COL_W-1:0]        reqCol,
  input  logic [BEATS*DATA_W-1:0] reqWrData,
  input  logic [BEATS*BE_W-1:0]   reqWrBe,
  output logic                    sdCsN,
  output logic                    sdRasN,
  output logic                    sdCasN,
  output logic                    sdWeN,
  output logic [ADDR_W-1:0]       sdAddr,
  output logic [BE_W-1:0]         sdBe,
  output logic [DATA_W-1:0]       sdDqOut,
  output logic                    sdDqOe,
  input  logic [DATA_W-1:0]       sdDqIn,
  output logic                    rdValid,
  output logic [DATA_W-1:0]       rdData,
  output logic                    done
);

  seqStrobe_t strobe;

  sdram_seq_ctrl #(
    .BEATS (BEATS),
    .CNT_W (CNT_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfgTrcd  (cfgTrcd),
    .cfgTrp   (cfgTrp),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqReady (reqReady),
    .strobe   (strobe)
  );

  sdram_seq_dp #(
    .BEATS  (BEATS),
    .DATA_W (DATA_W),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .ADDR_W (ADDR_W),
    .MAX_CL (MAX_CL),
    .CL_W   (CL_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfgCasLat (cfgCasLat),
    .reqRow    (reqRow),
    .reqCol    (reqCol),
    .reqWrData (reqWrData),
    .reqWrBe   (reqWrBe),
    .sdCsN     (sdCsN),
    .sdRasN    (sdRasN),
    .sdCasN    (sdCasN),
    .sdWeN     (sdWeN),
    .sdAddr    (sdAddr),
    .sdBe      (sdBe),
    .sdDqOut   (sdDqOut),
    .sdDqOe    (sdDqOe),
    .sdDqIn    (sdDqIn),
    .rdValid   (rdValid),
    .rdData    (rdData),
    .done      (done)
  );

endmodule

// File: tb/sdram_burst_seq_tb.sv
module sdram_burst_seq_tb_top;

  localparam int MAXC = 4096;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [2:0]   cfgTrcd = 3'd2;
  logic [1:0]   cfgCasLat = 2'd2;
  logic [2:0]   cfgTrp = 3'd2;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic         reqWrite = 1'b0;
  logic [12:0]  reqRow = '0;
  logic [8:0]   reqCol = '0;
  logic [127:0] reqWrData = '0;
  logic [15:0]  reqWrBe = '0;
  logic         sdCsN, sdRasN, sdCasN, sdWeN;
  logic [12:0]  sdAddr;
  logic [3:0]   sdBe;
  logic [31:0]  sdDqOut;
  logic         sdDqOe;
  logic [31:0]  sdDqIn = '0;
  logic         rdValid;
  logic [31:0]  rdData;
  logic         done;

  sdram_burst_seq dut_i (
    .clk(clk), .rstN(rstN), .cfgTrcd(cfgTrcd), .cfgCasLat(cfgCasLat), .cfgTrp(cfgTrp),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite), .reqRow(reqRow),
    .reqCol(reqCol), .reqWrData(reqWrData), .reqWrBe(reqWrBe),
    .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN), .sdAddr(sdAddr),
    .sdBe(sdBe), .sdDqOut(sdDqOut), .sdDqOe(sdDqOe), .sdDqIn(sdDqIn),
    .rdValid(rdValid), .rdData(rdData), .done(done)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit monOn = 1'b0;
  bit finished = 1'b0;

  logic [3:0]  expCmd  [MAXC];
  logic [12:0] expAddr [MAXC];
  logic [3:0]  expBe   [MAXC];
  logic        expOe   [MAXC];
  logic [31:0] expDq   [MAXC];
  logic        expRdV  [MAXC];
  logic [31:0] expRdD  [MAXC];
  logic        expDone [MAXC];

  function automatic logic [31:0] pat(int c);
    return {c[15:0], ~c[15:0]} ^ 32'h3C5A_0000;
  endfunction

  // memory model: data pattern on sdDqIn depends only on the cycle index
  always @(negedge clk) sdDqIn <= pat(cyc);

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  function automatic string cmdReq(logic [3:0] c);
    case (c)
      4'b0011: return "R2";
      4'b0101, 4'b0100: return "R3";
      4'b0010: return "R6";
      default: return "R9";
    endcase
  endfunction

  initial begin
    for (int i = 0; i < MAXC; i++) begin
      expCmd[i] = 4'b0111; expAddr[i] = '0; expBe[i] = '0; expOe[i] = 1'b0;
      expDq[i] = '0; expRdV[i] = 1'b0; expRdD[i] = '0; expDone[i] = 1'b0;
    end
  end

  // per-cycle comparison against the reference timeline
  always @(negedge clk) begin
    if (monOn && cyc < MAXC) begin
      logic [3:0] got;
      got = {sdCsN, sdRasN, sdCasN, sdWeN};
      chk(got == expCmd[cyc], cmdReq(expCmd[cyc]), 128'(got), 128'(expCmd[cyc]));
      if (expCmd[cyc] != 4'b0111) begin
        if (expCmd[cyc] == 4'b0010)
          chk(sdAddr[10] == 1'b1, "R6", 128'(sdAddr), 128'(expAddr[cyc]));
        else
          chk(sdAddr == expAddr[cyc], cmdReq(expCmd[cyc]), 128'(sdAddr), 128'(expAddr[cyc]));
      end
      if (expCmd[cyc] == 4'b0100)
        chk(sdBe == expBe[cyc], "R4", 128'(sdBe), 128'(expBe[cyc]));
      if (expCmd[cyc] == 4'b0101)
        chk(sdBe == 4'hF, "R5", 128'(sdBe), 128'h F);
      chk(sdDqOe == expOe[cyc], "R4", 128'(sdDqOe), 128'(expOe[cyc]));
      if (expOe[cyc])
        chk(sdDqOut == expDq[cyc], "R4", 128'(sdDqOut), 128'(expDq[cyc]));
      chk(rdValid == expRdV[cyc], "R5", 128'(rdValid), 128'(expRdV[cyc]));
      if (expRdV[cyc])
        chk(rdData == expRdD[cyc], "R5", 128'(rdData), 128'(expRdD[cyc]));
      chk(done == expDone[cyc], "R8", 128'(done), 128'(expDone[cyc]));
    end
  end

  // fill the reference timeline for one burst whose ACTV lands at cycle act
  task automatic sched(int act, bit wr, logic [12:0] row, logic [8:0] col,
                       logic [127:0] data, logic [15:0] be, int trcd, int cl,
                       output int pallCyc);
    expCmd[act]  = 4'b0011;
    expAddr[act] = row;
    for (int i = 0; i < 4; i++) begin
      int c;
      c = act + trcd + i;
      expCmd[c]  = wr ? 4'b0100 : 4'b0101;
      expAddr[c] = 13'(9'(col + 9'(i)));
      if (wr) begin
        expBe[c] = be[4*i +: 4];
        expOe[c] = 1'b1;
        expDq[c] = data[32*i +: 32];
        if (i == 3) expDone[c] = 1'b1;
      end else begin
        expRdV[c + cl + 1] = 1'b1;
        expRdD[c + cl + 1] = pat(c + cl);
        if (i == 3) expDone[c + cl + 1] = 1'b1;
      end
    end
    pallCyc = act + trcd + 4;
    expCmd[pallCyc] = 4'b0010;
  endtask

  // present a request at the current negedge; ACTV expected at actCyc
  task automatic issue(int actCyc, bit wr, logic [12:0] row, logic [8:0] col,
                       logic [127:0] data, logic [15:0] be, string req,
                       output int pallCyc);
    chk(reqReady == 1'b1, req, 128'(reqReady), 128'h1);
    reqValid  = 1'b1;
    reqWrite  = wr;
    reqRow    = row;
    reqCol    = col;
    reqWrData = data;
    reqWrBe   = be;
    sched(actCyc, wr, row, col, data, be, int'(cfgTrcd), int'(cfgCasLat), pallCyc);
    @(negedge clk);
    reqValid  = 1'b0;
    reqWrData = {4{$urandom()}};
    reqWrBe   = 16'($urandom());
  endtask

  task automatic waitUntil(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic oneIdle(bit wr, logic [12:0] row, logic [8:0] col,
                         logic [127:0] data, logic [15:0] be);
    int p;
    issue(cyc + 1, wr, row, col, data, be, "R1", p);
    waitUntil(p + int'(cfgTrp) + int'(cfgCasLat) + 3);
  endtask

  initial begin
    int p, p2;
    void'($urandom(32'd2468));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    monOn = 1'b1;
    // R1 reset state
    chk({sdCsN, sdRasN, sdCasN, sdWeN} == 4'b0111, "R1", 128'({sdCsN, sdRasN, sdCasN, sdWeN}), 128'h7);
    chk(reqReady == 1'b1, "R1", 128'(reqReady), 128'h1);
    chk(rdValid == 1'b0 && done == 1'b0 && sdDqOe == 1'b0, "R1",
        128'({rdValid, done, sdDqOe}), 128'h0);
    @(negedge clk);

    // directed: reference timing, read then write
    cfgTrcd = 3'd2; cfgCasLat = 2'd2; cfgTrp = 3'd2;
    oneIdle(1'b0, 13'h1ABC, 9'h010, '0, '0);
    oneIdle(1'b1, 13'h0123, 9'h020, {32'hDDDD0003, 32'hCCCC0002, 32'hBBBB0001, 32'hAAAA0000}, 16'hA5C3);

    // directed: column wrap at the top of the range
    oneIdle(1'b0, 13'h1FFF, 9'h1FE, '0, '0);

    // directed: every CAS latency with minimum activate delay
    for (int l = 1; l <= 3; l++) begin
      cfgTrcd = 3'd1; cfgCasLat = 2'(l); cfgTrp = 3'd1;
      oneIdle(1'b0, 13'(l), 9'h100, '0, '0);
    end

    // R7 early acceptance during PALL (read then read)
    cfgTrcd = 3'd2; cfgCasLat = 2'd2; cfgTrp = 3'd3;
    issue(cyc + 1, 1'b0, 13'h0444, 9'h004, '0, '0, "R1", p);
    waitUntil(p);
    issue(p + 3, 1'b0, 13'h0555, 9'h008, '0, '0, "R7", p2);
    waitUntil(p2 + 3 + 2 + 3);

    // R7 early acceptance during the precharge wait (read then write)
    issue(cyc + 1, 1'b0, 13'h0666, 9'h00C, '0, '0, "R1", p);
    waitUntil(p + 1);
    issue(p + 3, 1'b1, 13'h0777, 9'h1FF, {4{32'h1234_5678}}, 16'hF00F, "R7", p2);
    waitUntil(p2 + 3 + 2 + 3);

    // R7 acceptance in PALL with a one-cycle precharge (write then write)
    cfgTrcd = 3'd3; cfgCasLat = 2'd3; cfgTrp = 3'd1;
    issue(cyc + 1, 1'b1, 13'h0888, 9'h040, {4{32'hCAFE_0001}}, 16'h1248, "R1", p);
    waitUntil(p);
    issue(p + 1, 1'b1, 13'h0999, 9'h044, {4{32'hBEEF_0002}}, 16'h8421, "R7", p2);
    waitUntil(p2 + 1 + 3 + 3);

    // constrained random bursts
    for (int n = 0; n < 40; n++) begin
      logic [127:0] d;
      cfgTrcd   = 3'(1 + ($urandom() % 4));
      cfgCasLat = 2'(1 + ($urandom() % 3));
      cfgTrp    = 3'(1 + ($urandom() % 4));
      d = {$urandom(), $urandom(), $urandom(), $urandom()};
      oneIdle(1'($urandom()), 13'($urandom()), 9'($urandom()), d, 16'($urandom()));
    end

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule